// File: doc/BRIEF.md
# Metering channel calibration engine

This block sits on one measurement channel of an energy-metering datapath. It takes signed Q1.23 instantaneous samples and the RMS value reported once per computation cycle. It keeps a DC offset register, a gain register and an AC offset register, and applies them to every sample and RMS value that passes through. A voltage channel and a current channel each use their own instance, so calibrating one leaves the other's registers alone.

When a command arrives, the engine runs one of four calibrations: DC offset, DC gain, AC offset or AC gain. Each one first lets a fixed number of samples pass so the filter can settle. It then measures either N instantaneous samples or a number of RMS reports. A single iterative restoring divider turns the measurement into a mean, a reciprocal or a ratio, and the result is written into the matching register. A gain that would reach 4.0 is clamped and flagged invalid. When a calibration finishes, a ready flag is set and an interrupt is raised if the mask allows it.

Top module: `chan_cal_engine`

## Requirements
- R1: Command code 0 (DC offset) skips 30 settling samples. It then stores the negated mean of the next N raw samples, truncated toward zero, into the DC offset register (select code 0).
- R2: Each input sample x produces, one cycle later, `sat24(((sat24(x + dc_off)) * gain) >>> 22)`. The gain is unsigned Q2.22.
- R3: Command code 1 (DC gain) sets gain to 1.0 (0x400000) as soon as it is accepted. After settling it averages N offset-corrected samples to a mean m and stores floor(2^45 / |m|).
- R4: A gain calibration whose quotient is 2^24 or more stores 0xFFFFFF and raises `gain_inv_o`. A gain calibration with a valid result clears `gain_inv_o`.
- R5: Command code 3 (AC gain) ignores RMS reports during settling. It takes the first RMS report r after settling and stores floor(gain * 5033165 / r), where 5033165 is 0.6 of full scale.
- R6: Command code 2 (AC offset) clears the AC offset register (select code 2) when accepted. After settling it stores the floor of the mean of 6 RMS reports.
- R7: Each RMS input r produces, one cycle later, max(r - ac_off, 0).
- R8: A DC calibration finishes only after at least N+30 samples have been received since the command. An AC offset calibration finishes only after the settling samples plus 6 RMS reports.
- R9: `drdy_o` is set when a calibration finishes. It is cleared by `drdy_clr_i` or by a newly accepted command. `irq_o` is `drdy_o` gated by `irq_mask_i`.
- R10: `busy_o` rises in the cycle after a command is accepted and falls when `drdy_o` is set. Commands that arrive while busy are ignored.
- R11: Registers are read and written through select codes: 0 DC offset, 1 gain, 2 AC offset, 3 N. Reset values are 0, 0x400000, 0, 16. Writing 0 to N stores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | DW | Signed Q1.23 instantaneous sample |
| smp_vld_i | input | 1 | Sample strobe |
| rms_i | input | DW | Unsigned RMS report |
| rms_vld_i | input | 1 | RMS report strobe |
| cmd_vld_i | input | 1 | Calibration command strobe |
| cmd_i | input | 2 | Calibration type |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select for write |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 2 | Register select for read |
| rd_data_o | output | DW | Read data |
| drdy_clr_i | input | 1 | Clears the ready flag |
| irq_mask_i | input | 1 | Interrupt enable for the ready flag |
| smp_o | output | DW | Corrected sample |
| smp_vld_o | output | 1 | Corrected sample strobe |
| rms_o | output | DW | Corrected RMS |
| rms_vld_o | output | 1 | Corrected RMS strobe |
| busy_o | output | 1 | Calibration in progress |
| drdy_o | output | 1 | Calibration finished |
| irq_o | output | 1 | Masked ready interrupt |
| gain_inv_o | output | 1 | Last gain calibration saturated |

## Verification
The bench builds the block with its default parameters: 24-bit data, a 12-bit N register, 30 settling samples and 6 AC offset reports. At run time it writes N as 8, so every calibration sequence, including both divider passes of a DC gain calibration, completes in a few hundred cycles. Because the full 24-bit width is kept, the gain ceiling of 4.0, sample saturation at both rails and the exact 0.6 target constant are all exercised at their real bit positions.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    CMD_DC_OFF  = 2'd0,
    CMD_DC_GAIN = 2'd1,
    CMD_AC_OFF  = 2'd2,
    CMD_AC_GAIN = 2'd3
  } cal_cmd_e;

  typedef enum logic [1:0] {
    SEL_DC_OFF = 2'd0,
    SEL_GAIN   = 2'd1,
    SEL_AC_OFF = 2'd2,
    SEL_N      = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ACC,
    ST_DIV_MEAN,
    ST_DIV_FIN
  } cal_st_e;
endpackage

// File: rtl/cal_div.sv
module cal_div #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W:0]       rem_q, rem_sh;
  logic [W-1:0]     quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;

  // numerator bits shift out of quo_q as quotient bits shift in
  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (rem_sh >= {1'b0, den_q}) begin
          rem_q <= rem_sh - {1'b0, den_q};
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        if (cnt_q == CNT_W'(W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/cal_corr.sv
module cal_corr #(
  parameter int DW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] smp_i,
  input  logic                 smp_vld_i,
  input  logic signed [DW-1:0] dc_off_i,
  input  logic [DW-1:0]        gain_i,
  input  logic [DW-1:0]        rms_i,
  input  logic                 rms_vld_i,
  input  logic [DW-1:0]        ac_off_i,
  output logic signed [DW-1:0] offs_smp_o,
  output logic signed [DW-1:0] smp_o,
  output logic                 smp_vld_o,
  output logic [DW-1:0]        rms_o,
  output logic                 rms_vld_o
);
  localparam int PW = 2 * DW + 2;
  localparam int FRAC = DW - 2;
  localparam logic signed [DW:0]   SUM_MAX = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0]   SUM_MIN = {2'b11, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] PRD_MAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] PRD_MIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW:0]   sum;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] scaled_sat;

  always_comb begin
    sum = {smp_i[DW-1], smp_i} + {dc_off_i[DW-1], dc_off_i};
    if (sum > SUM_MAX)      offs_smp_o = SUM_MAX[DW-1:0];
    else if (sum < SUM_MIN) offs_smp_o = SUM_MIN[DW-1:0];
    else                    offs_smp_o = sum[DW-1:0];
    prod   = $signed({{(PW-DW){offs_smp_o[DW-1]}}, offs_smp_o}) *
             $signed({{(PW-DW){1'b0}}, gain_i});
    scaled = prod >>> FRAC;
    if (scaled > PRD_MAX)      scaled_sat = PRD_MAX[DW-1:0];
    else if (scaled < PRD_MIN) scaled_sat = PRD_MIN[DW-1:0];
    else                       scaled_sat = scaled[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o     <= '0;
      smp_vld_o <= 1'b0;
      rms_o     <= '0;
      rms_vld_o <= 1'b0;
    end else begin
      smp_vld_o <= smp_vld_i;
      rms_vld_o <= rms_vld_i;
      if (smp_vld_i) smp_o <= scaled_sat;
      if (rms_vld_i) rms_o <= (rms_i > ac_off_i) ? rms_i - ac_off_i : '0;
    end
  end
endmodule

// File: rtl/chan_cal_engine.sv
module chan_cal_engine
  import cal_pkg::*;
#(
  parameter int DW         = 24,
  parameter int NW         = 12,
  parameter int SETTLE     = 30,
  parameter int AC_CYC     = 6,
  parameter int N_DEF      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_vld_i,
  input  logic [DW-1:0] rms_i,
  input  logic          rms_vld_i,
  input  logic          cmd_vld_i,
  input  logic [1:0]    cmd_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          drdy_clr_i,
  input  logic          irq_mask_i,
  output logic [DW-1:0] smp_o,
  output logic          smp_vld_o,
  output logic [DW-1:0] rms_o,
  output logic          rms_vld_o,
  output logic          busy_o,
  output logic          drdy_o,
  output logic          irq_o,
  output logic          gain_inv_o
);
  localparam int AW    = DW + NW + 1;
  localparam int DIV_W = 2 * DW;
  localparam int SW    = $clog2(SETTLE + AC_CYC + 1);
  localparam int CW    = (NW > SW) ? NW : SW;
  localparam logic [DW-1:0]    ONE    = DW'(1) << (DW - 2);
  localparam logic [DW-1:0]    GMAX   = {DW{1'b1}};
  localparam longint           TGT_L  = ((longint'(6) <<< (DW - 1)) + 5) / 10;
  localparam logic [DW-1:0]    TGT    = TGT_L[DW-1:0];
  localparam logic [DIV_W-1:0] DC_NUM = DIV_W'(1) << (2 * DW - 3);
  localparam logic [DIV_W-1:0] DMAX   = (DIV_W'(1) << (DW - 1)) - 1'b1;

  logic signed [DW-1:0] dc_off_q;
  logic [DW-1:0]        gain_q, ac_off_q;
  logic [NW-1:0]        n_q;
  cal_st_e              st_q;
  cal_cmd_e             op_q;
  logic [CW-1:0]        cnt_q;
  logic signed [AW-1:0] acc_q, acc_term, acc_nxt;
  logic [AW-1:0]        acc_abs;
  logic                 acc_neg_q, drdy_q, inv_q;
  logic                 div_go_q, div_done;
  logic [DIV_W-1:0]     div_num_q, div_den_q, quo;
  logic signed [DW-1:0] offs_smp;

  cal_corr #(.DW(DW)) corr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp_i),
    .smp_vld_i  (smp_vld_i),
    .dc_off_i   (dc_off_q),
    .gain_i     (gain_q),
    .rms_i      (rms_i),
    .rms_vld_i  (rms_vld_i),
    .ac_off_i   (ac_off_q),
    .offs_smp_o (offs_smp),
    .smp_o      (smp_o),
    .smp_vld_o  (smp_vld_o),
    .rms_o      (rms_o),
    .rms_vld_o  (rms_vld_o)
  );

  cal_div #(.W(DIV_W)) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_go_q),
    .num_i   (div_num_q),
    .den_i   (div_den_q),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  always_comb begin
    unique case (op_q)
      CMD_DC_OFF:  acc_term = {{(AW-DW){smp_i[DW-1]}}, smp_i};
      CMD_DC_GAIN: acc_term = {{(AW-DW){offs_smp[DW-1]}}, offs_smp};
      CMD_AC_OFF:  acc_term = {{(AW-DW){1'b0}}, rms_i};
      default:     acc_term = '0;
    endcase
    acc_nxt = acc_q + acc_term;
    acc_abs = acc_nxt[AW-1] ? AW'(-acc_nxt) : AW'(acc_nxt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_off_q  <= '0;
      gain_q    <= ONE;
      ac_off_q  <= '0;
      n_q       <= NW'(N_DEF);
      st_q      <= ST_IDLE;
      op_q      <= CMD_DC_OFF;
      cnt_q     <= '0;
      acc_q     <= '0;
      acc_neg_q <= 1'b0;
      drdy_q    <= 1'b0;
      inv_q     <= 1'b0;
      div_go_q  <= 1'b0;
      div_num_q <= '0;
      div_den_q <= '0;
    end else begin
      div_go_q <= 1'b0;
      if (wr_en_i) begin
        unique case (reg_sel_e'(wr_sel_i))
          SEL_DC_OFF: dc_off_q <= wr_data_i;
          SEL_GAIN:   gain_q   <= wr_data_i;
          SEL_AC_OFF: ac_off_q <= wr_data_i;
          default:    n_q      <= (wr_data_i[NW-1:0] == '0) ? NW'(1) : wr_data_i[NW-1:0];
        endcase
      end
      if (drdy_clr_i) drdy_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: if (cmd_vld_i) begin
          op_q   <= cal_cmd_e'(cmd_i);
          cnt_q  <= '0;
          drdy_q <= 1'b0;
          st_q   <= ST_SETTLE;
          if (cal_cmd_e'(cmd_i) == CMD_DC_GAIN) gain_q   <= ONE;
          if (cal_cmd_e'(cmd_i) == CMD_AC_OFF)  ac_off_q <= '0;
        end
        ST_SETTLE: if (smp_vld_i) begin
          if (cnt_q == CW'(SETTLE - 1)) begin
            cnt_q <= '0;
            acc_q <= '0;
            st_q  <= ST_ACC;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACC: begin
          unique case (op_q)
            CMD_DC_OFF, CMD_DC_GAIN: if (smp_vld_i) begin
              acc_q <= acc_nxt;
              if (cnt_q == CW'(n_q) - 1'b1) begin
                acc_neg_q <= acc_nxt[AW-1];
                div_num_q <= DIV_W'(acc_abs);
                div_den_q <= DIV_W'(n_q);
                div_go_q  <= 1'b1;
                st_q      <= ST_DIV_MEAN;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            CMD_AC_OFF: if (rms_vld_i) begin
              acc_q <= acc_nxt;
              if (cnt_q == CW'(AC_CYC - 1)) begin
                div_num_q <= DIV_W'(acc_nxt);
                div_den_q <= DIV_W'(AC_CYC);
                div_go_q  <= 1'b1;
                st_q      <= ST_DIV_FIN;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            default: if (rms_vld_i) begin
              // scale the present gain so a non-unity start value is honoured
              div_num_q <= DIV_W'(gain_q) * DIV_W'(TGT);
              div_den_q <= DIV_W'(rms_i);
              div_go_q  <= 1'b1;
              st_q      <= ST_DIV_FIN;
            end
          endcase
        end
        ST_DIV_MEAN: if (div_done) begin
          if (op_q == CMD_DC_OFF) begin
            if (acc_neg_q) dc_off_q <= (quo > DMAX) ? DMAX[DW-1:0] : quo[DW-1:0];
            else           dc_off_q <= -quo[DW-1:0];
            drdy_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            div_num_q <= DC_NUM;
            div_den_q <= quo;
            div_go_q  <= 1'b1;
            st_q      <= ST_DIV_FIN;
          end
        end
        ST_DIV_FIN: if (div_done) begin
          if (op_q == CMD_AC_OFF) begin
            ac_off_q <= quo[DW-1:0];
          end else if (|quo[DIV_W-1:DW]) begin
            gain_q <= GMAX;
            inv_q  <= 1'b1;
          end else begin
            gain_q <= quo[DW-1:0];
            inv_q  <= 1'b0;
          end
          drdy_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_DC_OFF: rd_data_o = dc_off_q;
      SEL_GAIN:   rd_data_o = gain_q;
      SEL_AC_OFF: rd_data_o = ac_off_q;
      default:    rd_data_o = DW'(n_q);
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign drdy_o     = drdy_q;
  assign irq_o      = drdy_q & irq_mask_i;
  assign gain_inv_o = inv_q;
endmodule

// File: rtl/cal_engine_chk.sv
module cal_engine_chk #(
  parameter int DW     = 24,
  parameter int NW     = 12,
  parameter int SETTLE = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_vld_i,
  input logic          smp_vld_o,
  input logic [DW-1:0] rms_i,
  input logic [DW-1:0] rms_o,
  input logic          rms_vld_o,
  input logic          cmd_vld_i,
  input logic          busy_o,
  input logic          drdy_o,
  input logic          gain_inv_o,
  input logic [1:0]    op_i,
  input logic [DW-1:0] gain_i,
  input logic [NW-1:0] n_i
);
  logic [31:0] smp_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      smp_cnt_q <= '0;
    else if (!busy_o && cmd_vld_i)    smp_cnt_q <= '0;
    else if (busy_o && smp_vld_i)     smp_cnt_q <= smp_cnt_q + 1'b1;
  end

  AST_SMP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> smp_vld_o); // R2
  AST_RMS_NOT_ABOVE_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rms_vld_o |-> (rms_o <= $past(rms_i))); // R7
  AST_INV_CLAMPS_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gain_inv_o) |-> (gain_i == {DW{1'b1}})); // R4
  AST_CMD_ACCEPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_vld_i) |=> busy_o); // R10
  AST_OP_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (op_i == $past(op_i))); // R10
  AST_DRDY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> $fell(busy_o)); // R9
  AST_DC_MIN_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !op_i[1]) |-> (smp_cnt_q >= 32'(n_i) + 32'(SETTLE))); // R8
endmodule

bind chan_cal_engine cal_engine_chk #(.DW(DW), .NW(NW), .SETTLE(SETTLE)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_vld_i  (smp_vld_i),
  .smp_vld_o  (smp_vld_o),
  .rms_i      (rms_i),
  .rms_o      (rms_o),
  .rms_vld_o  (rms_vld_o),
  .cmd_vld_i  (cmd_vld_i),
  .busy_o     (busy_o),
  .drdy_o     (drdy_o),
  .gain_inv_o (gain_inv_o),
  .op_i       (op_q),
  .gain_i     (gain_q),
  .n_i        (n_q)
);

// File: tb/chan_cal_engine_tb_top.sv
module chan_cal_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCAL = 8;
  localparam int SET = 30;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic [23:0] rms_i = '0;
  logic        rms_vld_i = 1'b0;
  logic        cmd_vld_i = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [23:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [23:0] rd_data_o;
  logic        drdy_clr_i = 1'b0;
  logic        irq_mask_i = 1'b0;
  logic [23:0] smp_o;
  logic        smp_vld_o;
  logic [23:0] rms_o;
  logic        rms_vld_o;
  logic        busy_o, drdy_o, irq_o, gain_inv_o;

  int     n_chk = 0;
  int     n_bad = 0;
  longint last_smp, last_rms;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  chan_cal_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
    .rms_i(rms_i), .rms_vld_i(rms_vld_i), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .drdy_clr_i(drdy_clr_i),
    .irq_mask_i(irq_mask_i), .smp_o(smp_o), .smp_vld_o(smp_vld_o),
    .rms_o(rms_o), .rms_vld_o(rms_vld_o), .busy_o(busy_o), .drdy_o(drdy_o),
    .irq_o(irq_o), .gain_inv_o(gain_inv_o)
  );

  function automatic longint sat24(input longint x);
    if (x > 64'sd8388607)  return 64'sd8388607;
    if (x < -64'sd8388608) return -64'sd8388608;
    return x;
  endfunction

  function automatic longint s24(input logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input longint data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data[23:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [23:0] val);
    rd_sel_i = sel;
    #1;
    val = rd_data_o;
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk_i);
    cmd_vld_i = 1'b1; cmd_i = c;
    @(negedge clk_i);
    cmd_vld_i = 1'b0;
  endtask

  task automatic send_smp(input longint v);
    @(negedge clk_i);
    smp_i = v[23:0]; smp_vld_i = 1'b1;
    @(negedge clk_i);
    smp_vld_i = 1'b0;
    last_smp = s24(smp_o);
  endtask

  task automatic send_rms(input longint v);
    @(negedge clk_i);
    rms_i = v[23:0]; rms_vld_i = 1'b1;
    @(negedge clk_i);
    rms_vld_i = 1'b0;
    last_rms = longint'(rms_o);
  endtask

  task automatic wait_drdy();
    for (int i = 0; i < 300; i++) begin
      if (drdy_o) break;
      @(negedge clk_i);
    end
  endtask

  // runs a DC calibration; sum covers samples 30..30+N-1 after the command
  task automatic run_dc(input logic [1:0] c, input longint base, input longint step,
                        input longint off_now, input bit poke, output longint sum,
                        output int cnt_done);
    longint v;
    sum = 0; cnt_done = 0;
    issue(c);
    for (int k = 0; k < 400; k++) begin
      v = base + (k % 5) * step - 2 * step;
      send_smp(v);
      if (k >= SET && k < SET + NCAL) sum += (c == 2'd0) ? v : sat24(v + off_now);
      if (poke && k == 10) issue(2'd3);
      if (drdy_o) begin cnt_done = k + 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [23:0] v;
    rd(2'd0, v); chk("R11 reset dc_off", s24(v), 0);
    rd(2'd1, v); chk("R11 reset gain", v, 24'h400000);
    rd(2'd2, v); chk("R11 reset ac_off", v, 0);
    rd(2'd3, v); chk("R11 reset N", v, 16);
    chk("R10 reset busy", busy_o, 0);
    chk("R9 reset drdy", drdy_o, 0);
    chk("R9 reset irq", irq_o, 0);
  endtask

  task automatic t_regs();
    logic [23:0] v;
    wr(2'd3, 0);    rd(2'd3, v); chk("R11 N zero write", v, 1);
    wr(2'd3, NCAL); rd(2'd3, v); chk("R11 N write", v, NCAL);
    wr(2'd2, 24'h000321); rd(2'd2, v); chk("R11 ac_off write", v, 24'h000321);
  endtask

  task automatic t_path();
    longint off, g;
    longint xs[5] = '{64'sh100000, 64'sh700000, -64'sh300000, -64'sh7ff000, 64'sd12345};
    off = -1000; g = 64'h800000;
    wr(2'd0, off); wr(2'd1, g);
    foreach (xs[i]) begin
      send_smp(xs[i]);
      chk("R2 corrected sample", last_smp, sat24((sat24(xs[i] + off) * g) >>> 22));
    end
    g = 64'h2ab123; off = 64'sh7fff00;
    wr(2'd0, off); wr(2'd1, g);
    send_smp(64'sh000400);
    chk("R2 offset saturation", last_smp, sat24((sat24(64'sh400 + off) * g) >>> 22));
    wr(2'd0, 0); wr(2'd1, 64'h400000);
    send_smp(-64'sd77);
    chk("R2 unity path", last_smp, -77);
  endtask

  task automatic t_dc_off();
    longint sum; int cnt; logic [23:0] v;
    wr(2'd0, 64'sd5000);
    run_dc(2'd0, -64'sh123456, 64'h777, 0, 1'b1, sum, cnt);
    chk("R8 DC offset sample count", cnt >= NCAL + SET, 1);
    rd(2'd0, v); chk("R1 DC offset result", s24(v), -(sum / NCAL));
    chk("R10 busy cleared at end", busy_o, 0);
    chk("R9 irq masked", irq_o, 0);
    irq_mask_i = 1'b1; #1;
    chk("R9 irq unmasked", irq_o, 1);
    @(negedge clk_i); drdy_clr_i = 1'b1; @(negedge clk_i); drdy_clr_i = 1'b0;
    chk("R9 drdy cleared", drdy_o, 0);
    chk("R9 irq after clear", irq_o, 0);
    irq_mask_i = 1'b0;
  endtask

  task automatic t_dc_gain(input longint base, input bit expect_inv);
    longint sum, m, g; int cnt; logic [23:0] v, off;
    rd(2'd0, off);
    wr(2'd1, 64'h123456);
    issue(2'd1);
    chk("R10 busy after accept", busy_o, 1);
    rd(2'd1, v); chk("R3 gain reset to one", v, 24'h400000);
    chk("R9 drdy cleared by cmd", drdy_o, 0);
    // command already issued, so run the sample loop directly
    sum = 0; cnt = 0;
    for (int k = 0; k < 400; k++) begin
      longint s;
      s = base + (k % 5) * 64'h800 - 2 * 64'h800;
      send_smp(s);
      if (k >= SET && k < SET + NCAL) sum += sat24(s + s24(off));
      if (drdy_o) begin cnt = k + 1; break; end
    end
    m = sum / NCAL; if (m < 0) m = -m;
    g = (m == 0) ? 64'h1000000 : (64'sd1 <<< 45) / m;
    chk("R8 DC gain sample count", cnt >= NCAL + SET, 1);
    rd(2'd1, v);
    if (expect_inv) begin
      chk("R4 gain clamp", v, 24'hffffff);
      chk("R4 invalid flag set", gain_inv_o, 1);
    end else begin
      chk("R3 DC gain result", v, g);
      chk("R4 invalid flag clear", gain_inv_o, 0);
    end
  endtask

  task automatic t_ac_gain(input longint g0, input longint r, input bit expect_inv);
    logic [23:0] v; longint g;
    wr(2'd1, g0);
    issue(2'd3);
    for (int k = 0; k < SET; k++) begin
      send_smp(64'sh1000);
      if (k == 5) send_rms(64'sd77);
    end
    send_rms(r);
    wait_drdy();
    chk("R9 AC gain drdy", drdy_o, 1);
    g = (g0 * 64'd5033165) / r;
    rd(2'd1, v);
    if (expect_inv) begin
      chk("R4 AC gain clamp", v, 24'hffffff);
      chk("R4 AC invalid set", gain_inv_o, 1);
    end else begin
      chk("R5 AC gain result", v, g);
      chk("R4 AC invalid cleared", gain_inv_o, 0);
    end
  endtask

  task automatic t_ac_off();
    logic [23:0] v; longint sum, exp_off;
    wr(2'd2, 64'h1234);
    issue(2'd2);
    rd(2'd2, v); chk("R6 AC offset cleared on start", v, 0);
    for (int k = 0; k < SET; k++) begin
      send_smp(64'sd0);
      if (k == 3) send_rms(64'd999999);
    end
    sum = 0;
    for (int i = 0; i < 6; i++) begin
      send_rms(64'd3000 + 17 * i * i);
      sum += 64'd3000 + 17 * i * i;
      if (i == 4) chk("R8 AC offset not early", drdy_o, 0);
    end
    wait_drdy();
    chk("R9 AC offset drdy", drdy_o, 1);
    exp_off = sum / 6;
    rd(2'd2, v); chk("R6 AC offset result", v, exp_off);
    send_rms(exp_off + 500);
    chk("R7 RMS minus offset", last_rms, 500);
    send_rms(exp_off - 10);
    chk("R7 RMS floor at zero", last_rms, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_path();
    t_dc_off();
    t_dc_gain(64'sh500000, 1'b0);
    t_dc_gain(64'sh080000, 1'b1);
    t_ac_gain(64'h400000, 64'h400000, 1'b0);
    t_ac_gain(64'd5033165, 64'h100000, 1'b1);
    t_ac_off();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule